// File: doc/BRIEF.md
# Vectored Interrupt Request Controller

This block gathers a set of device interrupt request lines and presents them to a processor as one interrupt request output with an acknowledge input. Every request line is edge-detected and remembered in a pending register, so bursts of simultaneous requests are all kept. Software can block individual lines with a per-line mask. A masked request stays pending and becomes eligible again as soon as its mask bit is cleared.

While any pending line is unmasked, the request output is high. When the processor raises its acknowledge input, the controller picks the highest-priority eligible line and freezes that choice. For as long as the acknowledge stays high, it drives that line's software-programmed 8-bit vector number on the vector output. It also clears the chosen line's pending bit.

Priority is a rotating fixed order. A programmable "top" line ranks first, and the other lines follow in ascending index, wrapping around. After reset the top line is line 0, so a lower index wins. Software writes vectors, the mask word and the top line through a single write port. The pending word is a plain output that software can read.

The acknowledge handshake is a level handshake, not a valid/ready stream. The processor holds the acknowledge high for as long as it needs the vector, and the vector cannot change during that time.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the pending word is 0, the mask is 0 (all lines enabled), the top line is 0, line i's vector is 32+i, `intr` is 0 and `vec_out` is 0.
- R2: A 0-to-1 change of `irq_in[i]` between two clock edges sets pending bit i at the second edge. A line that is held high does not set its bit again after the bit has been cleared.
- R3: Rising edges on several lines in the same cycle set all of their pending bits.
- R4: `intr` is high exactly when some pending bit has a zero mask bit. It goes low in the cycle after the last such bit clears.
- R5: At the clock edge where `inta` is first seen high, the controller chooses the winning eligible line and clears its pending bit. From then until the edge where `inta` is seen low, `vec_out` shows that line's vector; otherwise `vec_out` is 0.
- R6: With top line T, priority order is T, T+1, ..., N-1, 0, ..., T-1. With T=0 (the reset value) a lower index wins.
- R7: A line whose mask bit is 1 keeps its pending bit but never causes `intr` or wins an acknowledge. Clearing its mask bit makes it eligible at once.
- R8: During an acknowledge, `vec_out` does not change, even if a higher-priority request arrives or the chosen line's vector is rewritten.
- R9: An acknowledge that starts while no line is eligible drives `vec_out` = 0 and clears no pending bit.
- R10: Config writes (`cfg_we`=1) decode `cfg_op`. A value of 0 writes `cfg_wdata[7:0]` to the vector of line `cfg_idx`. A value of 1 writes `cfg_wdata[N-1:0]` to the mask (bit i = line i). A value of 2 sets the top line to `cfg_idx`. A value of 3 changes nothing.
- R11: If the chosen line's pending bit is cleared at the same edge that a new rising edge arrives on that line, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Device request lines, rising-edge sensitive |
| cfg_we | input | 1 | Config write strobe |
| cfg_op | input | 2 | Config operation: 0 vector, 1 mask, 2 top line, 3 none |
| cfg_idx | input | IDX_W | Line index for vector and top-line writes |
| cfg_wdata | input | CFG_W | Write data (vector byte or mask word) |
| pend_word | output | NUM_LINES | Pending bits, readable by software |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Interrupt acknowledge from the processor |
| vec_out | output | VEC_W | Vector of the acknowledged line, 0 when idle |

## Verification
The hardest situation to reach is a collision inside an acknowledge, where a request or a reprogramming arrives after the choice has been frozen. The bench reaches it by raising `inta`, then raising a higher-priority line and rewriting the chosen line's vector while `inta` is still held. A second hard case is a new edge on the line being cleared at the very edge the acknowledge starts. The bench reaches it by driving `inta` high and that line's request high in the same cycle. Masked-but-pending lines are reached by masking a line before pulsing it, then unmasking it later.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    CFG_VECTOR = 2'd0,
    CFG_MASK   = 2'd1,
    CFG_TOP    = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] clr_bits,
  output logic [NUM_LINES-1:0] pend
);
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      // a fresh edge wins over a clear of the same line
      pend  <= (pend & ~clr_bits) | rise;
    end
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int CFG_W     = 8,
  parameter int VEC_BASE  = 32,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_op,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [VEC_W-1:0]     vec_tab [NUM_LINES],
  output logic [NUM_LINES-1:0] mask,
  output logic [IDX_W-1:0]     top
);
  import irq_ctrl_pkg::*;

  logic idx_ok;
  assign idx_ok = (int'(cfg_idx) < NUM_LINES);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_tab[i] <= VEC_W'(VEC_BASE + i);
      else if (cfg_we && cfg_op_e'(cfg_op) == CFG_VECTOR && int'(cfg_idx) == i)
        vec_tab[i] <= cfg_wdata[VEC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      top  <= '0;
    end else if (cfg_we) begin
      case (cfg_op_e'(cfg_op))
        CFG_MASK: mask <= cfg_wdata[NUM_LINES-1:0];
        CFG_TOP:  if (idx_ok) top <= cfg_idx;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic [NUM_LINES-1:0] elig,
  input  logic [IDX_W-1:0]     top,
  output logic                 found,
  output logic [IDX_W-1:0]     sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      int p;
      p = int'(top) + k;
      if (p >= NUM_LINES) p = p - NUM_LINES;
      if (!found && elig[p]) begin
        found = 1'b1;
        sel   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int VEC_BASE  = 32,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CFG_W    = (NUM_LINES > VEC_W) ? NUM_LINES : VEC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_op,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [NUM_LINES-1:0] pend_word,
  output logic                 intr,
  input  logic                 inta,
  output logic [VEC_W-1:0]     vec_out
);
  logic [VEC_W-1:0]     vec_tab [NUM_LINES];
  logic [NUM_LINES-1:0] mask_w;
  logic [IDX_W-1:0]     top_w;
  logic [NUM_LINES-1:0] elig;
  logic [NUM_LINES-1:0] clr_bits;
  logic                 found;
  logic [IDX_W-1:0]     sel;
  logic                 inta_q;
  logic                 ack_rise;
  logic [IDX_W-1:0]     sel_q;
  logic [VEC_W-1:0]     vec_q;

  irq_pend_latch #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .clr_bits(clr_bits), .pend(pend_word)
  );

  irq_cfg_regs #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .CFG_W(CFG_W),
    .VEC_BASE(VEC_BASE), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .vec_tab(vec_tab), .mask(mask_w), .top(top_w)
  );

  assign elig = pend_word & ~mask_w;
  assign intr = |elig;

  irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .top(top_w), .found(found), .sel(sel)
  );

  assign ack_rise = inta & ~inta_q;
  assign clr_bits = (ack_rise && found) ? (NUM_LINES'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inta_q <= 1'b0;
      sel_q  <= '0;
      vec_q  <= '0;
    end else begin
      inta_q <= inta;
      if (ack_rise) begin
        sel_q <= sel;
        vec_q <= found ? vec_tab[sel] : '0;
      end
    end
  end

  assign vec_out = inta_q ? vec_q : '0;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 inta,
  input logic                 intr,
  input logic [VEC_W-1:0]     vec_out,
  input logic [NUM_LINES-1:0] pend_word,
  input logic                 ack_busy,
  input logic [IDX_W-1:0]     sel_q,
  input logic [NUM_LINES-1:0] mask_q
);
  logic [NUM_LINES-1:0] irq_d;
  logic                 inta_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d  <= '0;
      inta_d <= 1'b0;
    end else begin
      irq_d  <= irq_in;
      inta_d <= inta;
    end
  end

  // R2 / R3: every observed rising edge lands in the pending word
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_in & ~irq_d)) |=>
      ((pend_word & $past(irq_in & ~irq_d)) == $past(irq_in & ~irq_d)));

  // R5: an acknowledge with an eligible line removes one pending bit
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !inta_d && intr) |=>
      ($countones(pend_word) <
       $past($countones(pend_word)) + $past($countones(irq_in & ~irq_d))));

  // R7: the frozen choice never names a masked line
  a_r7_no_masked_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !inta_d && intr) |=>
      (($past(mask_q) & (NUM_LINES'(1) << sel_q)) == '0));

  // R8: vector output is steady throughout an acknowledge
  a_r8_vec_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_busy && $past(ack_busy)) |-> $stable(vec_out));
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .inta(inta), .intr(intr),
  .vec_out(vec_out), .pend_word(pend_word), .ack_busy(inta_q),
  .sel_q(sel_q), .mask_q(mask_w)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_op = 2'd0;
  logic [2:0] cfg_idx = 3'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [N-1:0] pend_word;
  logic       intr;
  logic       inta = 1'b0;
  logic [7:0] vec_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl #(.NUM_LINES(N), .VEC_W(8), .VEC_BASE(32)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
    .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .pend_word(pend_word), .intr(intr), .inta(inta), .vec_out(vec_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_in = irq_in | m;
    tick();
    irq_in = irq_in & ~m;
    tick();
  endtask

  task automatic cfg_write(input logic [1:0] op, input logic [2:0] idx, input logic [7:0] d);
    cfg_we = 1'b1; cfg_op = op; cfg_idx = idx; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ack(output int v);
    inta = 1'b1;
    tick();
    v = vec_out;
    inta = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    check(pend_word == 0, "R1 pending", pend_word, 0);
    check(intr == 0, "R1 intr", intr, 0);
    check(vec_out == 0, "R1 vec_out", vec_out, 0);
  endtask

  task automatic t_single();
    int v;
    pulse(8'h08);
    check(pend_word == 8'h08, "R2 pending after edge", pend_word, 8'h08);
    check(intr == 1, "R4 intr high", intr, 1);
    ack(v);
    check(v == 35, "R5 vector line3", v, 35);
    check(pend_word == 0, "R5 pending cleared", pend_word, 0);
    check(intr == 0, "R4 intr low", intr, 0);
    check(vec_out == 0, "R5 idle vec_out", vec_out, 0);
  endtask

  task automatic t_level();
    int v;
    irq_in[2] = 1'b1;
    tick(); tick();
    check(pend_word == 8'h04, "R2 level sets once", pend_word, 8'h04);
    ack(v);
    check(v == 34, "R5 vector line2", v, 34);
    tick(); tick();
    check(pend_word == 0, "R2 held level no re-set", pend_word, 0);
    irq_in[2] = 1'b0;
    tick();
  endtask

  task automatic t_multi();
    int v;
    pulse(8'h52);
    check(pend_word == 8'h52, "R3 all held", pend_word, 8'h52);
    ack(v); check(v == 33, "R6 first line1", v, 33);
    ack(v); check(v == 36, "R6 second line4", v, 36);
    ack(v); check(v == 38, "R6 third line6", v, 38);
    check(intr == 0, "R4 drained", intr, 0);
  endtask

  task automatic t_prog_vec();
    int v;
    cfg_write(2'd0, 3'd5, 8'd50);
    cfg_write(2'd0, 3'd6, 8'd51);
    pulse(8'h60);
    ack(v); check(v == 50, "R10 vector write line5", v, 50);
    ack(v); check(v == 51, "R10 vector write line6", v, 51);
  endtask

  task automatic t_mask();
    int v;
    cfg_write(2'd1, 3'd0, 8'h01);
    pulse(8'h01);
    check(pend_word == 8'h01, "R7 masked stays pending", pend_word, 1);
    check(intr == 0, "R7 masked no intr", intr, 0);
    pulse(8'h80);
    ack(v); check(v == 39, "R7 masked line skipped", v, 39);
    check(pend_word == 8'h01, "R7 masked bit kept", pend_word, 1);
    cfg_write(2'd1, 3'd0, 8'h00);
    check(intr == 1, "R7 unmask eligible", intr, 1);
    ack(v); check(v == 32, "R7 unmasked delivered", v, 32);
  endtask

  task automatic t_top();
    int v;
    cfg_write(2'd2, 3'd5, 8'd0);
    pulse(8'h44);
    ack(v); check(v == 51, "R6 rotated top picks line6", v, 51);
    ack(v); check(v == 34, "R6 rotated then line2", v, 34);
    cfg_write(2'd3, 3'd2, 8'h99);
    check(intr == 0 && pend_word == 0, "R10 op3 no state change", pend_word, 0);
    cfg_write(2'd2, 3'd0, 8'd0);
    pulse(8'h84);
    ack(v); check(v == 34, "R10 op3 left vector, R6 top back to 0", v, 34);
    ack(v); check(v == 39, "R6 line7 last", v, 39);
  endtask

  task automatic t_freeze();
    int v;
    pulse(8'h10);
    inta = 1'b1;
    tick();
    check(vec_out == 36, "R5 vector line4", vec_out, 36);
    irq_in[0] = 1'b1;
    cfg_we = 1'b1; cfg_op = 2'd0; cfg_idx = 3'd4; cfg_wdata = 8'h77;
    tick();
    check(vec_out == 36, "R8 frozen under new request", vec_out, 36);
    irq_in[0] = 1'b0; cfg_we = 1'b0;
    tick();
    check(vec_out == 36, "R8 frozen after vector write", vec_out, 36);
    inta = 1'b0;
    tick();
    check(pend_word == 8'h01, "R8 late request pending", pend_word, 1);
    ack(v); check(v == 32, "R8 late request served", v, 32);
  endtask

  task automatic t_spurious();
    inta = 1'b1;
    tick();
    check(vec_out == 0, "R9 no eligible vec 0", vec_out, 0);
    inta = 1'b0;
    tick();
    check(pend_word == 0, "R9 nothing cleared", pend_word, 0);
  endtask

  task automatic t_same_edge();
    int v;
    pulse(8'h08);
    inta = 1'b1;
    irq_in[3] = 1'b1;
    tick();
    check(vec_out == 35, "R11 vector line3", vec_out, 35);
    check(pend_word == 8'h08, "R11 new edge kept", pend_word, 8'h08);
    inta = 1'b0;
    irq_in[3] = 1'b0;
    tick();
    ack(v); check(v == 35, "R11 second delivery", v, 35);
    check(pend_word == 0, "R11 drained", pend_word, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_level();
    t_multi();
    t_prog_vec();
    t_mask();
    t_top();
    t_freeze();
    t_spurious();
    t_same_edge();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule